// File: doc/BRIEF.md
# Ethernet MAC Low-Power Sequencer

This block takes a small Ethernet MAC into and out of a clock-gated low-power state. The host sets a power request bit in a configuration register. The sequencer then withdraws the enables of the transmit and receive engines, so that a frame already in flight still finishes. It waits until neither engine is busy and the receive FIFO and the transmit-completion FIFO both report empty. Only then does it drop the clock enables for the transmit, receive and core clock domains. A request that arrives while traffic is still moving stays pending in the draining state until these conditions hold.

While gated, the host register bus stays live, but only the configuration, control and bank-select registers respond. Any other access is dropped: a write has no effect, a read returns zero, and a sticky access-error flag is set. Writing the control register clears the flag. Clearing the power request turns the clocks back on at once. The block then spends a fixed settling period before it reports ready. During that period, writes to the transmit-enable and receive-enable registers are refused. A separate register drives the PHY power-down output directly.

Top module: `eth_lp_seq`

## Requirements
- R1: After reset, the state is ACTIVE (code 0), all three clock enables are high, mac_ready is high, tx_enable, rx_enable, phy_pwrdn and access_err are low, and hb_rdata is zero.
- R2: The register indices are 0 configuration (bit 0 = power request), 1 control, 2 bank select (2 bits), 3 transmit enable (bit 0), 4 receive enable (bit 0), 5 PHY power-down (bit 0) and 6 status. A read returns its data on hb_rdata in the cycle after the request. A read of index 7, and any cycle without a read, gives zero.
- R3: tx_enable and rx_enable follow bit 0 of their registers only in ACTIVE and are low in every other state.
- R4: When the power request bit is set in ACTIVE, the state goes to DRAINING (code 1) on the next clock.
- R5: DRAINING moves to GATED (code 2) only on a clock where tx_busy and rx_busy are low and rx_fifo_empty and txc_fifo_empty are high. Otherwise it stays in DRAINING.
- R6: clk_en_tx, clk_en_rx and clk_en_core are low exactly while the state is GATED.
- R7: Clearing the power request in DRAINING returns the state to ACTIVE without ever gating.
- R8: In GATED, an access to an index above 2 is dropped: a write changes nothing, a read returns zero, and access_err is set.
- R9: access_err stays set until a write to the control register. Accesses to indices 0 to 2 behave normally in GATED.
- R10: Clearing the power request in GATED moves the state to WAKING (code 3) with the clocks on. After WAKE_CYCLES (16) clocks in WAKING it returns to ACTIVE. mac_ready is high only in ACTIVE.
- R11: Writes to the transmit-enable and receive-enable registers made in WAKING are ignored.
- R12: phy_pwrdn equals bit 0 of the PHY power-down register.
- R13: The status register reads {access_err, mac_ready, state[1:0]} in bits 3:0. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock, never gated |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hb_sel | input | 1 | Host access strobe, one access per cycle |
| hb_wr | input | 1 | 1 = write, 0 = read |
| hb_addr | input | 3 | Register index |
| hb_wdata | input | 16 | Write data |
| hb_rdata | output | 16 | Read data, one cycle after the request |
| tx_busy | input | 1 | Transmit engine has a frame in progress |
| rx_busy | input | 1 | Receive engine has a frame in progress |
| rx_fifo_empty | input | 1 | Receive FIFO holds no packets |
| txc_fifo_empty | input | 1 | Transmit-completion FIFO holds no entries |
| tx_enable | output | 1 | Enable to the transmit engine |
| rx_enable | output | 1 | Enable to the receive engine |
| phy_pwrdn | output | 1 | PHY power-down request |
| clk_en_tx | output | 1 | Clock enable, transmit domain |
| clk_en_rx | output | 1 | Clock enable, receive domain |
| clk_en_core | output | 1 | Clock enable, MAC core |
| mac_ready | output | 1 | Clocks running and settled |
| lp_state | output | 2 | Current state code |
| access_err | output | 1 | Sticky flag for a dropped access while gated |

## Verification
A register write takes effect on the clock edge that samples it, so enables and phy_pwrdn change right after that edge. A change of the power request moves the state one clock later, and read data appears one clock after the read strobe. The DRAINING to GATED step happens on the first edge where the quiet condition holds, and ACTIVE returns exactly sixteen edges after WAKING begins. The bench model advances on the same edges with the same one-edge delays and compares every output at the falling edge, when nothing is in transition. Directed checks wait a generous fixed number of cycles before they sample settled values.

// File: rtl/eth_lp_pkg.sv
package eth_lp_pkg;

  typedef enum logic [1:0] {
    LP_ACTIVE = 2'd0,
    LP_DRAIN  = 2'd1,
    LP_GATED  = 2'd2,
    LP_WAKE   = 2'd3
  } lp_state_e;

  // register indices; the open set while gated is 0..LAST_OPEN_REG
  localparam int unsigned REG_CFG  = 0;
  localparam int unsigned REG_CTRL = 1;
  localparam int unsigned REG_BANK = 2;
  localparam int unsigned REG_TXC  = 3;
  localparam int unsigned REG_RXC  = 4;
  localparam int unsigned REG_PHY  = 5;
  localparam int unsigned REG_STAT = 6;
  localparam int unsigned NUM_REGS = 7;
  localparam int unsigned LAST_OPEN_REG = 2;

endpackage

// File: rtl/eth_lp_filter.sv
module eth_lp_filter
  import eth_lp_pkg::*;
#(
  parameter int AW   = 3,
  parameter int NREG = NUM_REGS
) (
  input  lp_state_e           state_i,
  input  logic                sel_i,
  input  logic                wr_i,
  input  logic [AW-1:0]       addr_i,
  output logic [NREG-1:0]     wr_vec_o,
  output logic                rd_req_o,
  output logic                rd_ok_o,
  output logic                viol_o
);

  logic gated;
  logic waking;
  logic open_addr;
  logic wr_ok;

  always_comb begin
    gated     = (state_i == LP_GATED);
    waking    = (state_i == LP_WAKE);
    open_addr = (addr_i <= AW'(LAST_OPEN_REG));
    viol_o    = sel_i & gated & ~open_addr;
    rd_req_o  = sel_i & ~wr_i;
    rd_ok_o   = rd_req_o & ~viol_o;
    wr_ok     = sel_i & wr_i & ~viol_o;
  end

  // one write strobe per register; read-only and engine-enable variants
  for (genvar i = 0; i < NREG; i++) begin : g_wstrb
    if (i == REG_STAT) begin : g_ro
      assign wr_vec_o[i] = 1'b0;
    end else if ((i == REG_TXC) || (i == REG_RXC)) begin : g_eng
      assign wr_vec_o[i] = wr_ok & (addr_i == AW'(i)) & ~waking;
    end else begin : g_rw
      assign wr_vec_o[i] = wr_ok & (addr_i == AW'(i));
    end
  end

endmodule

// File: rtl/eth_lp_regs.sv
module eth_lp_regs
  import eth_lp_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW     = 3,
  parameter int NREG   = NUM_REGS,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [NREG-1:0]   wr_vec_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              rd_ok_i,
  input  logic              viol_i,
  input  lp_state_e         state_i,
  input  logic              ready_i,
  output logic              pwr_req_o,
  output logic              txc_o,
  output logic              rxc_o,
  output logic              phy_o,
  output logic              err_o,
  output logic [DW-1:0]     rdata_o
);

  logic [DW-1:0]     cfg_q, cfg_d;
  logic [DW-1:0]     ctrl_q, ctrl_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic              txc_q, txc_d;
  logic              rxc_q, rxc_d;
  logic              phy_q, phy_d;
  logic              err_q, err_d;
  logic [DW-1:0]     rdata_q, rdata_d;
  logic [DW-1:0]     rd_val;

  always_comb begin
    case (addr_i)
      AW'(REG_CFG):  rd_val = cfg_q;
      AW'(REG_CTRL): rd_val = ctrl_q;
      AW'(REG_BANK): rd_val = DW'(bank_q);
      AW'(REG_TXC):  rd_val = DW'(txc_q);
      AW'(REG_RXC):  rd_val = DW'(rxc_q);
      AW'(REG_PHY):  rd_val = DW'(phy_q);
      AW'(REG_STAT): rd_val = DW'({err_q, ready_i, state_i});
      default:       rd_val = '0;
    endcase
  end

  always_comb begin
    cfg_d   = wr_vec_i[REG_CFG]  ? wdata_i : cfg_q;
    ctrl_d  = wr_vec_i[REG_CTRL] ? wdata_i : ctrl_q;
    bank_d  = wr_vec_i[REG_BANK] ? wdata_i[BANK_W-1:0] : bank_q;
    txc_d   = wr_vec_i[REG_TXC]  ? wdata_i[0] : txc_q;
    rxc_d   = wr_vec_i[REG_RXC]  ? wdata_i[0] : rxc_q;
    phy_d   = wr_vec_i[REG_PHY]  ? wdata_i[0] : phy_q;
    if (viol_i) begin
      err_d = 1'b1;
    end else if (wr_vec_i[REG_CTRL]) begin
      err_d = 1'b0;
    end else begin
      err_d = err_q;
    end
    rdata_d = rd_ok_i ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      ctrl_q  <= '0;
      bank_q  <= '0;
      txc_q   <= 1'b0;
      rxc_q   <= 1'b0;
      phy_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      cfg_q   <= cfg_d;
      ctrl_q  <= ctrl_d;
      bank_q  <= bank_d;
      txc_q   <= txc_d;
      rxc_q   <= rxc_d;
      phy_q   <= phy_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign pwr_req_o = cfg_q[0];
  assign txc_o     = txc_q;
  assign rxc_o     = rxc_q;
  assign phy_o     = phy_q;
  assign err_o     = err_q;
  assign rdata_o   = rdata_q;

  // R8
  viol_err_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    viol_i |=> err_q);

  // R11
  wake_block_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_i == LP_WAKE) |=> ($stable(txc_q) && $stable(rxc_q)));

  // R9
  ctrl_clr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_vec_i[REG_CTRL] && !viol_i) |=> !err_q);

endmodule

// File: rtl/eth_lp_fsm.sv
module eth_lp_fsm
  import eth_lp_pkg::*;
#(
  parameter int WAKE_CYCLES = 16
) (
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      pwr_req_i,
  input  logic      tx_busy_i,
  input  logic      rx_busy_i,
  input  logic      rxf_empty_i,
  input  logic      txcf_empty_i,
  output lp_state_e state_o,
  output logic      clk_on_o,
  output logic      ready_o
);

  localparam int CW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYCLES - 1);

  lp_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          quiet;

  always_comb begin
    quiet   = ~tx_busy_i & ~rx_busy_i & rxf_empty_i & txcf_empty_i;
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      LP_ACTIVE: begin
        if (pwr_req_i) state_d = LP_DRAIN;
      end
      LP_DRAIN: begin
        if (!pwr_req_i) begin
          state_d = LP_ACTIVE;
        end else if (quiet) begin
          state_d = LP_GATED;
        end
      end
      LP_GATED: begin
        cnt_d = '0;
        if (!pwr_req_i) state_d = LP_WAKE;
      end
      LP_WAKE: begin
        if (cnt_q == WAKE_LAST) begin
          state_d = LP_ACTIVE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = LP_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LP_ACTIVE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o  = state_q;
  assign clk_on_o = (state_q != LP_GATED);
  assign ready_o  = (state_q == LP_ACTIVE);

  // R5
  gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == LP_GATED && $past(state_q) == LP_DRAIN)
      |-> $past(!tx_busy_i && !rx_busy_i && rxf_empty_i && txcf_empty_i));

  // R10
  wake_len_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == LP_ACTIVE && $past(state_q) == LP_WAKE) |-> ($past(cnt_q) == WAKE_LAST));

  // R7
  gate_entry_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == LP_GATED) |-> ($past(state_q) == LP_DRAIN || $past(state_q) == LP_GATED));

endmodule

// File: rtl/eth_lp_seq.sv
module eth_lp_seq
  import eth_lp_pkg::*;
#(
  parameter int DW          = 16,
  parameter int AW          = 3,
  parameter int BANK_W      = 2,
  parameter int WAKE_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hb_sel,
  input  logic          hb_wr,
  input  logic [AW-1:0] hb_addr,
  input  logic [DW-1:0] hb_wdata,
  output logic [DW-1:0] hb_rdata,
  input  logic          tx_busy,
  input  logic          rx_busy,
  input  logic          rx_fifo_empty,
  input  logic          txc_fifo_empty,
  output logic          tx_enable,
  output logic          rx_enable,
  output logic          phy_pwrdn,
  output logic          clk_en_tx,
  output logic          clk_en_rx,
  output logic          clk_en_core,
  output logic          mac_ready,
  output logic [1:0]    lp_state,
  output logic          access_err
);

  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  lp_state_e           state;
  logic                clk_on;
  logic                ready;
  logic [NUM_REGS-1:0] wr_vec;
  logic                rd_req;
  logic                rd_ok;
  logic                viol;
  logic                pwr_req;
  logic                txc;
  logic                rxc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  eth_lp_filter #(.AW(AW), .NREG(NUM_REGS)) u_filter (
    .state_i  (state),
    .sel_i    (hb_sel),
    .wr_i     (hb_wr),
    .addr_i   (hb_addr),
    .wr_vec_o (wr_vec),
    .rd_req_o (rd_req),
    .rd_ok_o  (rd_ok),
    .viol_o   (viol)
  );

  eth_lp_regs #(.DW(DW), .AW(AW), .NREG(NUM_REGS), .BANK_W(BANK_W)) u_regs (
    .clk       (clk),
    .rst_ni    (rst_int_n),
    .wr_vec_i  (wr_vec),
    .wdata_i   (hb_wdata),
    .addr_i    (hb_addr),
    .rd_ok_i   (rd_ok),
    .viol_i    (viol),
    .state_i   (state),
    .ready_i   (ready),
    .pwr_req_o (pwr_req),
    .txc_o     (txc),
    .rxc_o     (rxc),
    .phy_o     (phy_pwrdn),
    .err_o     (access_err),
    .rdata_o   (hb_rdata)
  );

  eth_lp_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_fsm (
    .clk          (clk),
    .rst_ni       (rst_int_n),
    .pwr_req_i    (pwr_req),
    .tx_busy_i    (tx_busy),
    .rx_busy_i    (rx_busy),
    .rxf_empty_i  (rx_fifo_empty),
    .txcf_empty_i (txc_fifo_empty),
    .state_o      (state),
    .clk_on_o     (clk_on),
    .ready_o      (ready)
  );

  assign clk_en_tx   = clk_on;
  assign clk_en_rx   = clk_on;
  assign clk_en_core = clk_on;
  assign mac_ready   = ready;
  assign lp_state    = state;
  assign tx_enable   = txc & ready;
  assign rx_enable   = rxc & ready;

  // R6
  gate_fall_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(clk_en_core) |-> ($past(state) == LP_DRAIN));

  // R3
  eng_en_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_enable || rx_enable) |-> (lp_state == 2'd0));

  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_req |=> (hb_rdata == '0));

endmodule

// File: tb/eth_lp_seq_tb.sv
module eth_lp_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WAKE_N     = 16;

  logic        clk;
  logic        rst_n;
  logic        hb_sel, hb_wr;
  logic [2:0]  hb_addr;
  logic [15:0] hb_wdata;
  logic [15:0] hb_rdata;
  logic        tx_busy, rx_busy, rx_fifo_empty, txc_fifo_empty;
  logic        tx_enable, rx_enable, phy_pwrdn;
  logic        clk_en_tx, clk_en_rx, clk_en_core, mac_ready, access_err;
  logic [1:0]  lp_state;

  int errors = 0;
  int checks = 0;
  bit cmp_on = 0;

  eth_lp_seq u_dut (
    .clk(clk), .rst_n(rst_n), .hb_sel(hb_sel), .hb_wr(hb_wr), .hb_addr(hb_addr),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .tx_busy(tx_busy), .rx_busy(rx_busy),
    .rx_fifo_empty(rx_fifo_empty), .txc_fifo_empty(txc_fifo_empty),
    .tx_enable(tx_enable), .rx_enable(rx_enable), .phy_pwrdn(phy_pwrdn),
    .clk_en_tx(clk_en_tx), .clk_en_rx(clk_en_rx), .clk_en_core(clk_en_core),
    .mac_ready(mac_ready), .lp_state(lp_state), .access_err(access_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int          m_state, m_cnt, m_rsync;
  logic [15:0] m_cfg, m_ctrl, m_rdata;
  logic [1:0]  m_bank;
  logic        m_txc, m_rxc, m_phy, m_err;

  function automatic logic [15:0] m_read(input int a);
    case (a)
      0: return m_cfg;
      1: return m_ctrl;
      2: return {14'd0, m_bank};
      3: return {15'd0, m_txc};
      4: return {15'd0, m_rxc};
      5: return {15'd0, m_phy};
      6: return {12'd0, m_err, (m_state == 0), m_state[1:0]};
      default: return 16'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || m_rsync < 2) begin
      if (!rst_n) m_rsync = 0; else m_rsync = m_rsync + 1;
      m_state = 0; m_cnt = 0; m_cfg = 0; m_ctrl = 0; m_rdata = 0;
      m_bank = 0; m_txc = 0; m_rxc = 0; m_phy = 0; m_err = 0;
    end else begin
      int          a, ns, nc;
      bit          viol, quiet;
      logic [15:0] nrd;
      a     = int'(hb_addr);
      viol  = hb_sel && (m_state == 2) && (a > 2);
      nrd   = (hb_sel && !hb_wr && !viol) ? m_read(a) : 16'd0;
      quiet = !tx_busy && !rx_busy && rx_fifo_empty && txc_fifo_empty;
      ns = m_state; nc = m_cnt;
      case (m_state)
        0: if (m_cfg[0]) ns = 1;
        1: if (!m_cfg[0]) ns = 0; else if (quiet) ns = 2;
        2: begin nc = 0; if (!m_cfg[0]) ns = 3; end
        default: if (m_cnt == WAKE_N-1) begin ns = 0; nc = 0; end else nc = m_cnt + 1;
      endcase
      if (viol) m_err = 1'b1;
      if (hb_sel && hb_wr && !viol) begin
        case (a)
          0: m_cfg = hb_wdata;
          1: begin m_ctrl = hb_wdata; m_err = 1'b0; end
          2: m_bank = hb_wdata[1:0];
          3: if (m_state != 3) m_txc = hb_wdata[0];
          4: if (m_state != 3) m_rxc = hb_wdata[0];
          5: m_phy = hb_wdata[0];
          default: ;
        endcase
      end
      m_rdata = nrd; m_state = ns; m_cnt = nc;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R4 R5 R7 R10 state", {14'd0, lp_state}, 16'(m_state));
      chk("R6 clk_en", {13'd0, clk_en_tx, clk_en_rx, clk_en_core},
          (m_state == 2) ? 16'd0 : 16'd7);
      chk("R10 mac_ready", {15'd0, mac_ready}, {15'd0, (m_state == 0)});
      chk("R3 R11 engine enables", {14'd0, tx_enable, rx_enable},
          {14'd0, m_txc && (m_state == 0), m_rxc && (m_state == 0)});
      chk("R12 phy_pwrdn", {15'd0, phy_pwrdn}, {15'd0, m_phy});
      chk("R8 R9 access_err", {15'd0, access_err}, {15'd0, m_err});
      chk("R2 R8 R13 rdata", hb_rdata, m_rdata);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus(input bit w, input int a, input logic [15:0] d);
    @(negedge clk);
    hb_sel = 1'b1; hb_wr = w; hb_addr = 3'(a); hb_wdata = d;
    @(negedge clk);
    hb_sel = 1'b0; hb_wr = 1'b0; hb_addr = 3'd0; hb_wdata = 16'd0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hb_sel = 0; hb_wr = 0; hb_addr = 0; hb_wdata = 0;
    tx_busy = 0; rx_busy = 0; rx_fifo_empty = 1; txc_fifo_empty = 1;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    cmp_on = 1'b1;
    // R1 reset state
    chk("R1 state", {14'd0, lp_state}, 16'd0);
    chk("R1 clocks", {13'd0, clk_en_tx, clk_en_rx, clk_en_core}, 16'd7);
    chk("R1 outputs", {11'd0, mac_ready, tx_enable, rx_enable, phy_pwrdn, access_err}, 16'h10);
    chk("R1 rdata", hb_rdata, 16'd0);

    // R2 register access while active
    bus(1, 1, 16'hA5C3);
    bus(1, 2, 16'hFFFF);
    bus(0, 1, 0);
    bus(0, 2, 0);
    bus(0, 7, 0);
    bus(1, 6, 16'hFFFF);   // R13 write ignored
    bus(0, 6, 0);
    // R3 R12 enable engines and PHY power-down
    bus(1, 3, 16'd1);
    bus(1, 4, 16'd1);
    bus(1, 5, 16'd1);
    idle(2);
    chk("R3 tx_enable active", {15'd0, tx_enable}, 16'd1);
    chk("R12 phy_pwrdn set", {15'd0, phy_pwrdn}, 16'd1);

    // R4 R5 request while a frame is in flight
    tx_busy = 1'b1;
    bus(1, 0, 16'd1);
    idle(6);
    chk("R5 held in draining", {14'd0, lp_state}, 16'd1);
    chk("R3 enables off while draining", {14'd0, tx_enable, rx_enable}, 16'd0);
    tx_busy = 1'b0; rx_fifo_empty = 1'b0;
    idle(4);
    chk("R5 held on fifo", {14'd0, lp_state}, 16'd1);
    rx_busy = 1'b1; rx_fifo_empty = 1'b1;
    idle(3);
    rx_busy = 1'b0; txc_fifo_empty = 1'b0;
    idle(3);
    txc_fifo_empty = 1'b1;
    idle(3);
    chk("R6 gated clocks off", {15'd0, clk_en_core}, 16'd0);

    // R8 R9 filter while gated
    bus(1, 3, 16'd0);
    bus(0, 3, 0);
    idle(1);
    chk("R8 error set", {15'd0, access_err}, 16'd1);
    bus(1, 2, 16'd1);
    bus(0, 2, 0);
    bus(0, 0, 0);
    bus(1, 1, 16'h0042);
    idle(1);
    chk("R9 error cleared", {15'd0, access_err}, 16'd0);
    bus(0, 6, 0);
    bus(1, 5, 16'd0);
    bus(1, 1, 16'h0001);

    // R10 R11 wake with blocked enable writes
    bus(1, 0, 16'd0);
    bus(1, 3, 16'd0);
    bus(1, 4, 16'd0);
    bus(0, 6, 0);
    idle(5);
    chk("R10 not ready while waking", {15'd0, mac_ready}, 16'd0);
    idle(15);
    chk("R10 ready after wake", {15'd0, mac_ready}, 16'd1);
    chk("R11 tx enable kept", {15'd0, tx_enable}, 16'd1);

    // R7 cancel during draining
    rx_busy = 1'b1;
    bus(1, 0, 16'd1);
    idle(3);
    bus(1, 0, 16'd0);
    idle(3);
    chk("R7 back to active", {14'd0, lp_state}, 16'd0);
    rx_busy = 1'b0;

    // fast gate with idle engines, wake, then reassert during wake
    bus(1, 0, 16'd1);
    idle(4);
    bus(1, 0, 16'd0);
    idle(3);
    bus(1, 0, 16'd1);
    idle(25);
    chk("R5 regated after wake", {14'd0, lp_state}, 16'd2);
    bus(1, 0, 16'd0);
    idle(20);
    bus(1, 3, 16'd0);
    bus(1, 5, 16'd0);
    idle(2);
    chk("R12 phy_pwrdn clear", {15'd0, phy_pwrdn}, 16'd0);
    chk("R3 tx_enable clear", {15'd0, tx_enable}, 16'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule